// File: doc/BRIEF.md
# Sequential Integer Multiplier with Zero Early-Out

This block is a multi-cycle integer multiplier with two operand sizes. In narrow mode it multiplies the low 8 bits of each operand into a 16-bit product. In wide mode it multiplies two 16-bit operands into a 32-bit product. A mode input selects two's-complement or unsigned operation. A start pulse captures the operands. The block then runs a shift-add datapath that retires two multiplier bits per cycle. It answers with a one-cycle done pulse and a registered product.

How long an operation takes depends on the data. When the second operand (the multiplier, `op_b`) is zero, the block skips the datapath and returns zero after a short fixed time. Otherwise the block always takes a fixed number of cycles per size. A result that is negative takes longer, because the block multiplies operand magnitudes and then spends an extra pass negating the product. A client that issues start can therefore predict the exact latency from the operands, and it reads the product when done fires.

Top module: `seq_mult_eo`

## Requirements
- R1: Narrow mode (`word_mode`=0) places the 16-bit product of `op_a[7:0]` and `op_b[7:0]` in `product[15:0]`, and `product[31:16]` reads zero.
- R2: Wide mode (`word_mode`=1) places the 32-bit product of `op_a` and `op_b` in `product[31:0]`.
- R3: With `signed_mode`=1 both operands and the product are two's complement. With `signed_mode`=0 all are unsigned.
- R4: If the multiplier operand is zero, done goes high in the cycle after the 3rd rising edge following the edge that sampled start, and product is 0, whatever `op_a` holds. The multiplier operand is `op_b[7:0]` in narrow mode and `op_b[15:0]` in wide mode.
- R5: In narrow mode with a nonzero multiplier, done follows the 12th edge after start for a non-negative result and the 13th edge for a negative one.
- R6: In wide mode with a nonzero multiplier, done follows the 16th edge after start for a non-negative result and the 19th edge for a negative one.
- R7: A result counts as negative only in signed mode, when the operand signs differ and both operands are nonzero. Unsigned operations and a zero `op_a` always take the non-negative latency.
- R8: done is high for exactly one cycle per accepted operation.
- R9: product changes only in the cycle that done goes high, and otherwise holds its value, including while operands change and while a new operation runs.
- R10: start is ignored while an operation is in progress. The running operation keeps its operands, its result and its latency.
- R11: In narrow mode, `op_a[15:8]` and `op_b[15:8]` have no effect on the product or the latency.
- R12: After reset, done is 0 and product is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the present operands and modes |
| word_mode | input | 1 | 0: 8x8 narrow multiply, 1: 16x16 wide multiply |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier; a zero value here takes the early-out |
| product | output | 32 | Registered result, updated with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start that arrives while an operation is running. The intruding start carries a zero multiplier that would take the early-out if it were accepted. The bench raises start in the middle of selected runs with such operands. It then checks that the first operation still ends at its own latency with its own product. A second case needs care: a zero multiplicand paired with a negative multiplier in signed mode. This case must keep the non-negative latency. The bench reaches it by sweeping `op_a` through 0 alongside signed corner values. In narrow runs, the bench fills the upper operand bits with values derived from the operands, so that those bits are visibly ignored.

// File: rtl/seq_mult_eo_pkg.sv
package seq_mult_eo_pkg;

   // Selects the cycle count for one operation from its class.
   function automatic int lat_pick(input logic wide, input logic neg, input logic zero,
                                   input int lz, input int lnp, input int lnn,
                                   input int lwp, input int lwn);
      int r;
      if (zero)
         r = lz;
      else if (wide)
         r = neg ? lwn : lwp;
      else
         r = neg ? lnn : lnp;
      return r;
   endfunction

endpackage

// File: rtl/seq_mult_eo_prep.sv
module seq_mult_eo_prep #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  logic [WIDE_W-1:0] op_a,
   input  logic [WIDE_W-1:0] op_b,
   input  logic              word_mode,
   input  logic              signed_mode,
   output logic [WIDE_W-1:0] mag_a,
   output logic [WIDE_W-1:0] mag_b,
   output logic              neg_res,
   output logic              b_zero
);
   logic [NARROW_W-1:0] na, nb, n_ma, n_mb;
   logic                n_sa, n_sb, w_sa, w_sb, a_nz;
   logic [WIDE_W-1:0]   w_ma, w_mb;

   always_comb begin
      na   = op_a[NARROW_W-1:0];
      nb   = op_b[NARROW_W-1:0];
      n_sa = signed_mode & na[NARROW_W-1];
      n_sb = signed_mode & nb[NARROW_W-1];
      w_sa = signed_mode & op_a[WIDE_W-1];
      w_sb = signed_mode & op_b[WIDE_W-1];
      n_ma = n_sa ? (~na + 1'b1) : na;
      n_mb = n_sb ? (~nb + 1'b1) : nb;
      w_ma = w_sa ? (~op_a + 1'b1) : op_a;
      w_mb = w_sb ? (~op_b + 1'b1) : op_b;
      if (word_mode) begin
         mag_a  = w_ma;
         mag_b  = w_mb;
         a_nz   = |op_a;
         b_zero = ~|op_b;
      end else begin
         mag_a  = WIDE_W'(n_ma);
         mag_b  = WIDE_W'(n_mb);
         a_nz   = |na;
         b_zero = ~|nb;
      end
      neg_res = (word_mode ? (w_sa ^ w_sb) : (n_sa ^ n_sb)) & a_nz & ~b_zero;
   end

endmodule

// File: rtl/seq_mult_eo_step.sv
module seq_mult_eo_step #(
   parameter int PROD_W     = 32,
   parameter int DIGIT_BITS = 2
) (
   input  logic [PROD_W-1:0]     acc_in,
   input  logic [PROD_W-1:0]     mcand,
   input  logic [DIGIT_BITS-1:0] digit,
   output logic [PROD_W-1:0]     acc_out
);
   generate
      if (DIGIT_BITS == 1) begin : g_r2
         assign acc_out = acc_in + (digit[0] ? mcand : '0);
      end else if (DIGIT_BITS == 2) begin : g_r4
         logic [PROD_W-1:0] pp0, pp1;
         assign pp0     = digit[0] ? mcand : '0;
         assign pp1     = digit[1] ? (mcand << 1) : '0;
         assign acc_out = acc_in + pp0 + pp1;
      end else begin : g_rn
         logic [PROD_W-1:0] sum;
         always_comb begin
            sum = acc_in;
            for (int i = 0; i < DIGIT_BITS; i++)
               if (digit[i]) sum = sum + (mcand << i);
         end
         assign acc_out = sum;
      end
   endgenerate
endmodule

// File: rtl/seq_mult_eo.sv
module seq_mult_eo
   import seq_mult_eo_pkg::*;
#(
   parameter int NARROW_W   = 8,
   parameter int WIDE_W     = 16,
   parameter int DIGIT_BITS = 2,
   parameter int LAT_ZERO   = 3,
   parameter int LAT_N_POS  = 12,
   parameter int LAT_N_NEG  = 13,
   parameter int LAT_W_POS  = 16,
   parameter int LAT_W_NEG  = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                word_mode,
   input  logic                signed_mode,
   input  logic [WIDE_W-1:0]   op_a,
   input  logic [WIDE_W-1:0]   op_b,
   output logic [2*WIDE_W-1:0] product,
   output logic                done
);
   localparam int PROD_W      = 2 * WIDE_W;
   localparam int ITER_NARROW = NARROW_W / DIGIT_BITS;
   localparam int ITER_WIDE   = WIDE_W / DIGIT_BITS;
   localparam int ITER_CW     = $clog2(ITER_WIDE + 1);
   localparam int MAX_LAT     = (LAT_W_NEG > LAT_N_NEG) ? LAT_W_NEG : LAT_N_NEG;
   localparam int CNT_W       = $clog2(MAX_LAT + 2);

   generate
      if (NARROW_W < 1 || NARROW_W > WIDE_W)
         $error("narrow width must be between 1 and the wide width");
      if (DIGIT_BITS < 1 || (NARROW_W % DIGIT_BITS) != 0 || (WIDE_W % DIGIT_BITS) != 0)
         $error("digit size must divide both operand widths");
      if (LAT_ZERO < 1)
         $error("early-out latency must be at least one cycle");
      if (LAT_N_POS < ITER_NARROW + 1 || LAT_N_NEG < ITER_NARROW + 2)
         $error("narrow latencies too short for the datapath");
      if (LAT_W_POS < ITER_WIDE + 1 || LAT_W_NEG < ITER_WIDE + 2)
         $error("wide latencies too short for the datapath");
   endgenerate

   logic [WIDE_W-1:0]  mag_a, mag_b;
   logic               neg_res, b_zero;
   logic [CNT_W-1:0]   target_d;

   logic               busy;
   logic [CNT_W-1:0]   tick, target_q;
   logic [ITER_CW-1:0] iters;
   logic               fix_pend, wide_q;
   logic [PROD_W-1:0]  mcand, acc, acc_step, acc_neg, neg_full;
   logic [WIDE_W-1:0]  mplier;

   seq_mult_eo_prep #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_prep (
      .op_a        (op_a),
      .op_b        (op_b),
      .word_mode   (word_mode),
      .signed_mode (signed_mode),
      .mag_a       (mag_a),
      .mag_b       (mag_b),
      .neg_res     (neg_res),
      .b_zero      (b_zero)
   );

   seq_mult_eo_step #(.PROD_W(PROD_W), .DIGIT_BITS(DIGIT_BITS)) u_step (
      .acc_in  (acc),
      .mcand   (mcand),
      .digit   (mplier[DIGIT_BITS-1:0]),
      .acc_out (acc_step)
   );

   assign target_d = CNT_W'(lat_pick(word_mode, neg_res, b_zero, LAT_ZERO,
                                     LAT_N_POS, LAT_N_NEG, LAT_W_POS, LAT_W_NEG));

   // Two's-complement correction, confined to the active product width.
   always_comb begin
      neg_full = ~acc + 1'b1;
      acc_neg  = wide_q ? neg_full : PROD_W'(neg_full[2*NARROW_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         tick     <= '0;
         target_q <= '0;
         iters    <= '0;
         fix_pend <= 1'b0;
         wide_q   <= 1'b0;
         mcand    <= '0;
         mplier   <= '0;
         acc      <= '0;
         product  <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               tick     <= CNT_W'(1);
               target_q <= target_d;
               wide_q   <= word_mode;
               mcand    <= PROD_W'(mag_a);
               mplier   <= b_zero ? '0 : mag_b;
               iters    <= b_zero ? '0 :
                           (word_mode ? ITER_CW'(ITER_WIDE) : ITER_CW'(ITER_NARROW));
               fix_pend <= neg_res;
               acc      <= '0;
            end
         end else begin
            tick <= tick + 1'b1;
            if (iters != '0) begin
               acc    <= acc_step;
               mcand  <= mcand << DIGIT_BITS;
               mplier <= mplier >> DIGIT_BITS;
               iters  <= iters - 1'b1;
            end else if (fix_pend) begin
               acc      <= acc_neg;
               fix_pend <= 1'b0;
            end
            if (tick == target_q) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               product <= acc;
            end
         end
      end
   end

endmodule

// File: rtl/seq_mult_eo_chk.sv
module seq_mult_eo_chk #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int LAT_ZERO = 3,
   parameter int MAX_LAT  = 19
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                word_mode,
   input logic [WIDE_W-1:0]   op_b,
   input logic [2*WIDE_W-1:0] product,
   input logic                done
);
   localparam int CW = $clog2(MAX_LAT + 2) + 1;

   logic          c_busy, c_zero, c_wide;
   logic [CW-1:0] c_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_busy <= 1'b0;
         c_zero <= 1'b0;
         c_wide <= 1'b0;
         c_cnt  <= '0;
      end else if ((!c_busy || done) && start) begin
         c_busy <= 1'b1;
         c_wide <= word_mode;
         c_zero <= word_mode ? (op_b == '0) : (op_b[NARROW_W-1:0] == '0);
         c_cnt  <= '0;
      end else if (done) begin
         c_busy <= 1'b0;
      end else if (c_busy) begin
         c_cnt <= c_cnt + 1'b1;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R8
   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));  // R9
   AST_DONE_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> c_busy);  // R10
   AST_ZERO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c_zero) |-> (c_cnt == CW'(LAT_ZERO) && product == '0));  // R4
   AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      c_busy |-> (c_cnt <= CW'(MAX_LAT)));  // R6
   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !c_wide) |-> (product[2*WIDE_W-1:2*NARROW_W] == '0));  // R1

endmodule

bind seq_mult_eo seq_mult_eo_chk #(
   .NARROW_W (NARROW_W),
   .WIDE_W   (WIDE_W),
   .LAT_ZERO (LAT_ZERO),
   .MAX_LAT  (MAX_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .word_mode (word_mode),
   .op_b      (op_b),
   .product   (product),
   .done      (done)
);

// File: tb/sim_seq_mult_eo.sv
`timescale 1ns/1ps
module sim_seq_mult_eo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word_mode = 1'b0;
   logic        signed_mode = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [31:0] product;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   seq_mult_eo u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
      .signed_mode(signed_mode), .op_a(op_a), .op_b(op_b),
      .product(product), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected product and latency, derived from the requirements.
   task automatic model(input logic [15:0] a, input logic [15:0] b, input bit wide,
                        input bit sgn, output logic [31:0] p, output int lat);
      longint va, vb, prod;
      logic [63:0] pv;
      if (wide) begin
         va = sgn ? longint'($signed(a)) : longint'(a);
         vb = sgn ? longint'($signed(b)) : longint'(b);
      end else begin
         va = sgn ? longint'($signed(a[7:0])) : longint'(a[7:0]);
         vb = sgn ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      end
      prod = va * vb;
      pv   = prod;
      if (vb == 0) begin
         p = '0; lat = 3;
      end else if (wide) begin
         p = pv[31:0]; lat = (prod < 0) ? 19 : 16;
      end else begin
         p = {16'h0, pv[15:0]}; lat = (prod < 0) ? 13 : 12;
      end
   endtask

   task automatic run(input logic [15:0] a, input logic [15:0] b, input bit wide,
                      input bit sgn, input bit intrude);
      logic [31:0] exp_p, held;
      int exp_lat, seen;
      string rl, rp;
      model(a, b, wide, sgn, exp_p, exp_lat);
      rl = (exp_lat == 3) ? "R4" : (wide ? "R6" : "R5");
      rp = (exp_lat == 3) ? "R4" : (sgn ? "R3" : (wide ? "R2" : "R1"));
      @(negedge clk);
      op_a = a; op_b = b; word_mode = wide; signed_mode = sgn; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      seen = 0;
      for (int j = 1; j <= 40; j++) begin
         if (intrude && j == 4) begin
            start = 1'b1; op_b = '0; op_a = 16'h7777; word_mode = ~wide;
         end else if (intrude && j == 5) begin
            start = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         if (done) begin seen = j; break; end
      end
      chk(seen == exp_lat, intrude ? "R10" : rl, "latency", seen, exp_lat);
      chk(product == exp_p, intrude ? "R10" : rp, "product", product, exp_p);
      held = product;
      op_a = ~a; op_b = ~b;
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done pulse width", done, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(product == held, "R9", "product hold", product, held);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] nc[6];
      logic [15:0] wc[8];
      nc = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h81};
      wc = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFEDC, 16'h0003};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R12", "reset done", done, 0);
      chk(product == '0, "R12", "reset product", product, 0);

      // R1 R3 R5 R11: narrow sweep with unrelated upper operand bits
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 256; a += 15)
            for (int b = 0; b < 256; b += 15)
               run({8'(a ^ 8'h5A), 8'(a)}, {8'(b * 3 + 1), 8'(b)}, 1'b0, s[0], 1'b0);
      // R7 R4: narrow corner values, including zero multiplicand with signed operands
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 6; i++)
            for (int k = 0; k < 6; k++)
               run({8'hC3, nc[i]}, {8'h3C, nc[k]}, 1'b0, s[0], 1'b0);
      // R2 R3 R6 R7: wide corner values
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 8; i++)
            for (int k = 0; k < 8; k++)
               run(wc[i], wc[k], 1'b1, s[0], 1'b0);
      // R10: start raised mid-run with a zero multiplier and the other mode
      run(16'h00FF, 16'h0081, 1'b0, 1'b1, 1'b1);
      run(16'h8000, 16'h0007, 1'b1, 1'b1, 1'b1);
      run(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule